// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit

This block turns 32-bit virtual addresses into physical addresses for a processor core. It holds two small lookup tables, one for instruction fetches and one for loads and stores. Each table is direct-mapped with one way. Every entry has a match word and a translate word. A request carries a virtual address, an access kind and the current privilege level. The block answers in the same cycle with either a physical address and its access rights, or a fault class.

Faults split into two classes. A miss is a tag mismatch or an entry whose valid bit is clear. A rights failure is an access that the entry's permission bits forbid for the current privilege level. When a strobed request faults, the block records an exception code and the faulting virtual address in registers. In the same cycle it raises a pulse that cancels any pending load-linked reservation. Software loads entries through a write port. A separate debug port resolves any address without faulting. When translation is disabled, every address passes through unchanged with full rights.

Top module: `xlat_unit`

## Requirements
- R1: An entry is written when wr_en_i is high at a clock edge. wr_tbl_i picks the table (0 data, 1 instruction), wr_sel_i picks the word (0 match, 1 translate), and wr_idx_i gives the slot. A lookup uses the slot equal to the virtual page number ANDed with ENTRIES-1.
- R2: A hit needs match word bits [31:PAGE_BITS] to equal the whole virtual page number. A page that aliases to the same slot with a different number misses.
- R3: Bit 0 of the match word is the valid bit. A tag match with that bit clear is reported as a miss (fault_class_o = 1), not as a rights failure.
- R4: For a fetch, execute right comes from translate bit 0 when req_super_i is 1, and from bit 1 otherwise. A fetch without it is a rights failure (fault_class_o = 2).
- R5: For a data access, read right comes from translate bit 0 (supervisor) or bit 2 (user), and write right from bit 1 (supervisor) or bit 3 (user). A load (req_kind_i = 1) needs read right. A store (req_kind_i = 2 or 3) needs write right.
- R6: On a hit, phys_addr_o is translate bits [31:PAGE_BITS] joined with the virtual offset bits. prot_o is {exec, write, read} for the current level, with the bits the table does not grant held at 0. On a miss, prot_o is 0.
- R7: When req_valid_i is high and the request faults, exc_code_o takes a new value at the clock edge: 1 for an instruction miss, 2 for a data miss, 3 for an instruction rights failure, 4 for a data rights failure.
- R8: On that same edge, fault_addr_o takes the faulting virtual address. Both registers hold their value otherwise. resv_clear_o is high in any cycle with a valid faulting request.
- R9: With xlat_en_i low, phys_addr_o equals req_vaddr_i, prot_o is 3'b111 and no fault is reported.
- R10: The debug port first returns a data-table hit that has read right for the current level (dbg_src_o = 0). Failing that, it returns an instruction-table hit that has execute right (dbg_src_o = 1). Otherwise it returns dbg_vaddr_i unchanged (dbg_src_o = 2). With translation disabled, dbg_src_o is 2.
- R11: Reset clears every entry to invalid and sets exc_code_o and fault_addr_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xlat_en_i | input | 1 | Translation enable |
| req_valid_i | input | 1 | Request strobe; qualifies fault recording |
| req_vaddr_i | input | ADDR_W | Request virtual address |
| req_kind_i | input | 2 | 0 fetch, 1 load, 2/3 store |
| req_super_i | input | 1 | 1 = supervisor level |
| phys_addr_o | output | ADDR_W | Translated address |
| prot_o | output | 3 | Rights {exec, write, read} |
| fault_o | output | 1 | Request faults |
| fault_class_o | output | 2 | 0 none, 1 miss, 2 rights |
| resv_clear_o | output | 1 | Cancel load-linked reservation |
| exc_code_o | output | 3 | Last recorded exception code |
| fault_addr_o | output | ADDR_W | Last faulting virtual address |
| wr_en_i | input | 1 | Entry write strobe |
| wr_tbl_i | input | 1 | 0 data table, 1 instruction table |
| wr_sel_i | input | 1 | 0 match word, 1 translate word |
| wr_idx_i | input | IDX_W | Entry slot |
| wr_data_i | input | ADDR_W | Word to write |
| dbg_vaddr_i | input | ADDR_W | Debug lookup address |
| dbg_paddr_o | output | ADDR_W | Debug result address |
| dbg_src_o | output | 2 | 0 data table, 1 instruction table, 2 untranslated |

## Verification
The bench builds the unit with ENTRIES = 8 and PAGE_BITS = 13. With only eight slots, page numbers 3 and 11 share a slot, so the full-tag comparison can be tested with small, readable addresses. Every slot can also be reached by name. The 8 KiB page keeps the offset split in the same place as the default build. Because of that, the physical address composition and the latched fault address are exercised just as in the default build.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;

  localparam logic [1:0] FC_NONE   = 2'd0;
  localparam logic [1:0] FC_MISS   = 2'd1;
  localparam logic [1:0] FC_RIGHTS = 2'd2;

  localparam logic [2:0] EXC_NONE  = 3'd0;
  localparam logic [2:0] EXC_IMISS = 3'd1;
  localparam logic [2:0] EXC_DMISS = 3'd2;
  localparam logic [2:0] EXC_IPF   = 3'd3;
  localparam logic [2:0] EXC_DPF   = 3'd4;

  localparam logic [1:0] SRC_DATA  = 2'd0;
  localparam logic [1:0] SRC_INSTR = 2'd1;
  localparam logic [1:0] SRC_PLAIN = 2'd2;
endpackage

// File: rtl/xlat_table.sv
`timescale 1ns/1ps
module xlat_table #(
  parameter int ENTRIES = 64,
  parameter int DW      = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             wsel_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  output logic [DW-1:0]    ra_match_o,
  output logic [DW-1:0]    ra_trans_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic [DW-1:0]    rb_match_o,
  output logic [DW-1:0]    rb_trans_o
);
  logic [DW-1:0] match_q [ENTRIES];
  logic [DW-1:0] trans_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        match_q[i] <= '0;
        trans_q[i] <= '0;
      end
    end else if (we_i) begin
      if (wsel_i) trans_q[widx_i] <= wdata_i;
      else        match_q[widx_i] <= wdata_i;
    end
  end

  assign ra_match_o = match_q[ra_idx_i];
  assign ra_trans_o = trans_q[ra_idx_i];
  assign rb_match_o = match_q[rb_idx_i];
  assign rb_trans_o = trans_q[rb_idx_i];
endmodule

// File: rtl/xlat_check.sv
`timescale 1ns/1ps
module xlat_check #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter bit IS_INSTR  = 1'b0
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [ADDR_W-1:0] match_i,
  input  logic [ADDR_W-1:0] trans_i,
  input  logic              store_i,
  input  logic              super_i,
  output logic              hit_o,
  output logic              allow_o,
  output logic [2:0]        prot_o,
  output logic [ADDR_W-1:0] paddr_o
);
  logic tag_eq;
  assign tag_eq  = match_i[ADDR_W-1:PAGE_BITS] == vaddr_i[ADDR_W-1:PAGE_BITS];
  assign hit_o   = tag_eq & match_i[0];
  assign paddr_o = {trans_i[ADDR_W-1:PAGE_BITS], vaddr_i[PAGE_BITS-1:0]};

  generate
    if (IS_INSTR) begin : g_exec
      logic x;
      assign x       = super_i ? trans_i[0] : trans_i[1];
      assign prot_o  = {x, 2'b00};
      assign allow_o = x;
    end else begin : g_data
      logic r, w;
      assign r       = super_i ? trans_i[0] : trans_i[2];
      assign w       = super_i ? trans_i[1] : trans_i[3];
      assign prot_o  = {1'b0, w, r};
      assign allow_o = store_i ? w : r;
    end
  endgenerate
endmodule

// File: rtl/xlat_unit.sv
`timescale 1ns/1ps
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int ENTRIES   = 64,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xlat_en_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_super_i,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic [2:0]        prot_o,
  output logic              fault_o,
  output logic [1:0]        fault_class_o,
  output logic              resv_clear_o,
  output logic [2:0]        exc_code_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  input  logic              wr_en_i,
  input  logic              wr_tbl_i,
  input  logic              wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] dbg_vaddr_i,
  output logic [ADDR_W-1:0] dbg_paddr_o,
  output logic [1:0]        dbg_src_o
);
  // index 0 = data table, 1 = instruction table
  logic [ADDR_W-1:0] ra_match [2];
  logic [ADDR_W-1:0] ra_trans [2];
  logic [ADDR_W-1:0] rb_match [2];
  logic [ADDR_W-1:0] rb_trans [2];
  logic [IDX_W-1:0]  req_idx, dbg_idx;

  assign req_idx = req_vaddr_i[PAGE_BITS +: IDX_W];
  assign dbg_idx = dbg_vaddr_i[PAGE_BITS +: IDX_W];

  generate
    for (genvar t = 0; t < 2; t++) begin : g_tbl
      xlat_table #(.ENTRIES(ENTRIES), .DW(ADDR_W)) u_tbl (
        .clk_i, .rst_ni,
        .we_i      (wr_en_i && (wr_tbl_i == t[0])),
        .wsel_i    (wr_sel_i),
        .widx_i    (wr_idx_i),
        .wdata_i   (wr_data_i),
        .ra_idx_i  (req_idx),
        .ra_match_o(ra_match[t]),
        .ra_trans_o(ra_trans[t]),
        .rb_idx_i  (dbg_idx),
        .rb_match_o(rb_match[t]),
        .rb_trans_o(rb_trans[t])
      );
    end
  endgenerate

  logic is_fetch, is_store;
  assign is_fetch = req_kind_i == KIND_FETCH;
  assign is_store = req_kind_i[1];

  logic              rd_hit, ri_hit, rd_ok, ri_ok;
  logic [2:0]        rd_prot, ri_prot;
  logic [ADDR_W-1:0] rd_pa, ri_pa;

  xlat_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IS_INSTR(1'b0)) u_req_d (
    .vaddr_i(req_vaddr_i), .match_i(ra_match[0]), .trans_i(ra_trans[0]),
    .store_i(is_store), .super_i(req_super_i),
    .hit_o(rd_hit), .allow_o(rd_ok), .prot_o(rd_prot), .paddr_o(rd_pa));

  xlat_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IS_INSTR(1'b1)) u_req_i (
    .vaddr_i(req_vaddr_i), .match_i(ra_match[1]), .trans_i(ra_trans[1]),
    .store_i(1'b0), .super_i(req_super_i),
    .hit_o(ri_hit), .allow_o(ri_ok), .prot_o(ri_prot), .paddr_o(ri_pa));

  logic sel_hit, sel_ok;
  logic [2:0] sel_prot;
  logic [ADDR_W-1:0] sel_pa;
  assign sel_hit  = is_fetch ? ri_hit  : rd_hit;
  assign sel_ok   = is_fetch ? ri_ok   : rd_ok;
  assign sel_prot = is_fetch ? ri_prot : rd_prot;
  assign sel_pa   = is_fetch ? ri_pa   : rd_pa;

  always_comb begin
    if (!xlat_en_i) begin
      phys_addr_o   = req_vaddr_i;
      prot_o        = 3'b111;
      fault_class_o = FC_NONE;
    end else if (!sel_hit) begin
      phys_addr_o   = sel_pa;
      prot_o        = 3'b000;
      fault_class_o = FC_MISS;
    end else begin
      phys_addr_o   = sel_pa;
      prot_o        = sel_prot;
      fault_class_o = sel_ok ? FC_NONE : FC_RIGHTS;
    end
  end

  assign fault_o      = fault_class_o != FC_NONE;
  assign resv_clear_o = req_valid_i && fault_o;

  logic [2:0] exc_d;
  always_comb begin
    if (fault_class_o == FC_MISS) exc_d = is_fetch ? EXC_IMISS : EXC_DMISS;
    else                          exc_d = is_fetch ? EXC_IPF   : EXC_DPF;
  end

  logic [2:0]        exc_q;
  logic [ADDR_W-1:0] fault_addr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_q        <= EXC_NONE;
      fault_addr_q <= '0;
    end else if (resv_clear_o) begin
      exc_q        <= exc_d;
      fault_addr_q <= req_vaddr_i;
    end
  end
  assign exc_code_o   = exc_q;
  assign fault_addr_o = fault_addr_q;

  // Debug path: data table, then instruction table, then untranslated
  logic              dd_hit, di_hit, dd_ok, di_ok;
  logic [2:0]        dd_prot, di_prot;
  logic [ADDR_W-1:0] dd_pa, di_pa;

  xlat_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IS_INSTR(1'b0)) u_dbg_d (
    .vaddr_i(dbg_vaddr_i), .match_i(rb_match[0]), .trans_i(rb_trans[0]),
    .store_i(1'b0), .super_i(req_super_i),
    .hit_o(dd_hit), .allow_o(dd_ok), .prot_o(dd_prot), .paddr_o(dd_pa));

  xlat_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IS_INSTR(1'b1)) u_dbg_i (
    .vaddr_i(dbg_vaddr_i), .match_i(rb_match[1]), .trans_i(rb_trans[1]),
    .store_i(1'b0), .super_i(req_super_i),
    .hit_o(di_hit), .allow_o(di_ok), .prot_o(di_prot), .paddr_o(di_pa));

  always_comb begin
    if (xlat_en_i && dd_hit && dd_ok) begin
      dbg_paddr_o = dd_pa;
      dbg_src_o   = SRC_DATA;
    end else if (xlat_en_i && di_hit && di_ok) begin
      dbg_paddr_o = di_pa;
      dbg_src_o   = SRC_INSTR;
    end else begin
      dbg_paddr_o = dbg_vaddr_i;
      dbg_src_o   = SRC_PLAIN;
    end
  end

  // R6
  offset_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> phys_addr_o[PAGE_BITS-1:0] == req_vaddr_i[PAGE_BITS-1:0]);
  // R9
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xlat_en_i |-> (phys_addr_o == req_vaddr_i && prot_o == 3'b111 && !fault_o));
  // R8
  addr_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && fault_o) |=> fault_addr_o == $past(req_vaddr_i));
  // R8
  exc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && fault_o) |=> ($stable(exc_code_o) && $stable(fault_addr_o)));
  // R7
  exc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && fault_o) |=> (exc_code_o >= 3'd1 && exc_code_o <= 3'd4));
  // R3
  miss_noprot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_class_o == FC_MISS |-> prot_o == 3'b000);
endmodule

// File: tb/xlat_unit_bench.sv
`timescale 1ns/1ps
module xlat_unit_bench;
  localparam int AW = 32;
  localparam int PB = 13;
  localparam int EN = 8;
  localparam int IW = $clog2(EN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          en, rv, sup, wen, wtbl, wsel;
  logic [AW-1:0] va, wdat, dva;
  logic [1:0]    kind;
  logic [IW-1:0] widx;
  logic [AW-1:0] pa, fa, dpa;
  logic [2:0]    prot, exc;
  logic          flt, rclr;
  logic [1:0]    fcl, dsrc;

  xlat_unit #(.ADDR_W(AW), .PAGE_BITS(PB), .ENTRIES(EN)) u_xlat_unit (
    .clk_i(clk), .rst_ni(rst_n), .xlat_en_i(en), .req_valid_i(rv),
    .req_vaddr_i(va), .req_kind_i(kind), .req_super_i(sup),
    .phys_addr_o(pa), .prot_o(prot), .fault_o(flt), .fault_class_o(fcl),
    .resv_clear_o(rclr), .exc_code_o(exc), .fault_addr_o(fa),
    .wr_en_i(wen), .wr_tbl_i(wtbl), .wr_sel_i(wsel), .wr_idx_i(widx),
    .wr_data_i(wdat), .dbg_vaddr_i(dva), .dbg_paddr_o(dpa), .dbg_src_o(dsrc));

  int tests = 0;
  int fails = 0;
  bit [31:0] mm [2][EN];
  bit [31:0] mt [2][EN];
  bit [2:0]  e_exc = 0;
  bit [31:0] e_fa  = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: tbl 0 data, 1 instr
  task automatic model(input bit [31:0] a, input int k, input bit s, input bit e,
                       output bit [31:0] p, output bit [2:0] pr, output int fc);
    int t, i;
    bit [31:0] m, tr;
    bit r, w, x;
    if (!e) begin p = a; pr = 3'b111; fc = 0; return; end
    t = (k == 0) ? 1 : 0;
    i = int'((a >> PB) % EN);
    m = mm[t][i]; tr = mt[t][i];
    p = {tr[31:PB], a[PB-1:0]};
    if ((m >> PB) != (a >> PB) || m[0] == 1'b0) begin pr = 0; fc = 1; return; end
    if (t == 1) begin
      x = s ? tr[0] : tr[1];
      pr = {x, 2'b00}; fc = x ? 0 : 2;
    end else begin
      r = s ? tr[0] : tr[2];
      w = s ? tr[1] : tr[3];
      pr = {1'b0, w, r};
      fc = (k >= 2) ? (w ? 0 : 2) : (r ? 0 : 2);
    end
  endtask

  task automatic wr(input bit t, input int i, input bit s, input bit [31:0] d);
    @(negedge clk);
    wen = 1; wtbl = t; widx = IW'(i); wsel = s; wdat = d;
    @(negedge clk);
    wen = 0;
    if (s) mt[t][i] = d; else mm[t][i] = d;
  endtask

  task automatic req(string tag, input bit [31:0] a, input int k, input bit s,
                     input bit e, input bit v);
    bit [31:0] p; bit [2:0] pr; int fc;
    @(negedge clk);
    va = a; kind = 2'(k); sup = s; en = e; rv = v;
    #1;
    model(a, k, s, e, p, pr, fc);
    chk(tag, "fault_class", 32'(fcl), 32'(fc));
    chk(tag, "prot", 32'(prot), 32'(pr));
    chk(tag, "resv_clear", 32'(rclr), 32'(v && fc != 0));
    if (fc == 0) chk(tag, "phys", pa, p);
    @(posedge clk);
    if (v && fc != 0) begin
      e_fa = a;
      e_exc = (fc == 1) ? ((k == 0) ? 3'd1 : 3'd2) : ((k == 0) ? 3'd3 : 3'd4);
    end
    #1;
    chk(tag, "exc_code", 32'(exc), 32'(e_exc));
    chk(tag, "fault_addr", fa, e_fa);
    rv = 0;
  endtask

  task automatic dbg(string tag, input bit [31:0] a, input bit s, input bit e,
                     input bit [31:0] ep, input int esrc);
    @(negedge clk);
    dva = a; sup = s; en = e; rv = 0;
    #1;
    chk(tag, "dbg_src", 32'(dsrc), 32'(esrc));
    chk(tag, "dbg_paddr", dpa, ep);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    en = 1; rv = 0; va = 0; kind = 0; sup = 1; wen = 0; wtbl = 0; wsel = 0;
    widx = 0; wdat = 0; dva = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R11 reset state
    chk("R11", "exc_code", 32'(exc), 0);
    chk("R11", "fault_addr", fa, 0);
    req("R11", 32'h0000_2040, 0, 1, 1, 0);

    // R1 data entry in slot 3: page 3 -> frame 0xABC, supervisor r/w only
    wr(0, 3, 0, (32'd3 << PB) | 32'd1);
    wr(0, 3, 1, (32'hABC << PB) | 32'h3);
    req("R1", 32'h0000_6123, 1, 1, 1, 1);
    req("R6", 32'h0000_7FFF, 2, 1, 1, 1);
    // R5 user has no rights on this page
    req("R5", 32'h0000_6010, 1, 0, 1, 1);
    req("R7", 32'h0000_6018, 2, 0, 1, 1);
    // R2 page 11 aliases to slot 3
    req("R2", 32'h0001_6004, 1, 1, 1, 1);
    // R3 tag equal, valid clear
    wr(0, 5, 0, 32'd5 << PB);
    wr(0, 5, 1, (32'h123 << PB) | 32'hF);
    req("R3", 32'h0000_A100, 1, 1, 1, 1);
    // R5 user read-only page, kind 3 acts as store
    wr(0, 6, 0, (32'd6 << PB) | 32'd1);
    wr(0, 6, 1, (32'h456 << PB) | 32'h4);
    req("R5", 32'h0000_C00C, 1, 0, 1, 1);
    req("R5", 32'h0000_C00C, 3, 0, 1, 1);
    // R4 instruction entry slot 2: user exec only
    wr(1, 2, 0, (32'd2 << PB) | 32'd1);
    wr(1, 2, 1, (32'h777 << PB) | 32'h2);
    req("R4", 32'h0000_4444, 0, 0, 1, 1);
    req("R4", 32'h0000_4448, 0, 1, 1, 1);
    // R7 instruction miss
    req("R7", 32'h0001_4000, 0, 1, 1, 1);
    // R8 faulting lookup without strobe leaves registers alone
    req("R8", 32'h00FF_0000, 1, 1, 1, 0);
    // R9 bypass
    req("R9", 32'h00FF_0000, 2, 0, 0, 1);
    req("R9", 32'h1234_5678, 0, 0, 0, 1);
    // R10 debug resolution order
    dbg("R10", 32'h0000_6010, 1, 1, (32'hABC << PB) | 32'h10, 0);
    dbg("R10", 32'h0000_4020, 0, 1, (32'h777 << PB) | 32'h20, 1);
    dbg("R10", 32'h0000_6010, 0, 1, 32'h0000_6010, 2);
    dbg("R10", 32'h0000_6010, 1, 0, 32'h0000_6010, 2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule